// File: doc/BRIEF.md
# Instruction Fetch Program-Counter Stage

This block is the front stage of an in-order pipeline. It keeps the program counter in a register that comes out of reset at a fixed start address. It presents that address to an instruction memory that answers within the same cycle. It then offers the address and the returned 32-bit word to the decode stage over a valid/ready handshake.

The next address is normally the current address plus four. A later stage can assert a redirect with a target address. While the redirect is active, it wins over everything else. The counter loads the target even if decode is stalling, and the word fetched in that cycle is never offered downstream. The counter moves only on an accepted transfer or on a redirect.

Top module: `fetch_pc_unit`

## Requirements
- R1: A synchronous active-high reset loads the program counter with parameter START_ADDR, so the first address presented after reset is START_ADDR.
- R2: When the output is valid and decode is ready, and no redirect is active, the next address is the current address plus 4.
- R3: When redirect_valid is high at a clock edge, the next address is redirect_pc.
- R4: When decode is not ready and no redirect is active, the program counter and the output payload are held unchanged.
- R5: While redirect_valid is high, out_valid is low, so the instruction being fetched in that cycle is discarded. When redirect_valid is low, out_valid is high.
- R6: imem_addr equals the current program counter. out_pc carries that address, and out_inst carries imem_data from the same cycle.
- R7: A redirect that arrives while decode is stalling still loads redirect_pc at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_valid | input | 1 | Control-hazard redirect from a later stage |
| redirect_pc | input | 32 | Redirect target address |
| imem_addr | output | 32 | Address to the combinational instruction memory |
| imem_data | input | 32 | Instruction word returned for imem_addr |
| out_valid | output | 1 | Payload to decode is valid |
| out_ready | input | 1 | Decode can accept the payload |
| out_pc | output | 32 | Address of the offered instruction |
| out_inst | output | 32 | Offered instruction word |

## Verification
The assertions check four things on every cycle: the step of plus four after an accepted transfer, the load of the redirect target, the hold during a stall, and the suppression of valid during a redirect. They also check that the payload always pairs the address with the word returned in that cycle. Some behaviour can only be shown by the bench's scenarios against its behavioural model. These are whole address streams across long runs, back-to-back redirects, a redirect that lands during a stall, and a reset taken in the middle of a run.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int XLEN    = 32;
    localparam int ILEN    = 32;
    localparam int PC_STEP = ILEN / 8;

    typedef logic [XLEN-1:0] addr_t;
    typedef logic [ILEN-1:0] word_t;

    typedef struct packed {
        addr_t pc;
        word_t inst;
    } fetch_pkt_t;

    function automatic addr_t seq_next(input addr_t pc);
        return pc + addr_t'(PC_STEP);
    endfunction
endpackage

// File: rtl/fetch_nextpc_sel.sv
module fetch_nextpc_sel
    import fetch_pkg::*;
(
    input  logic  redirect_valid,
    input  addr_t redirect_pc,
    input  addr_t cur_pc,
    output addr_t next_pc
);
    always_comb begin
        if (redirect_valid) next_pc = redirect_pc;
        else                next_pc = seq_next(cur_pc);
    end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter addr_t START_ADDR = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t d,
    output addr_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= START_ADDR;
        else if (load) q <= d;
    end
endmodule

// File: rtl/fetch_squash.sv
module fetch_squash
    import fetch_pkg::*;
(
    input  logic       redirect_valid,
    input  addr_t      pc,
    input  word_t      inst,
    output logic       valid,
    output fetch_pkt_t pkt
);
    always_comb begin
        valid    = ~redirect_valid;
        pkt.pc   = pc;
        pkt.inst = inst;
    end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter addr_t START_ADDR = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redirect_valid,
    input  logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_pc,
    output logic [ILEN-1:0] out_inst
);
    addr_t      pc_q;
    addr_t      pc_d;
    logic       pc_load;
    fetch_pkt_t pkt;

    fetch_nextpc_sel u_sel (
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .cur_pc         (pc_q),
        .next_pc        (pc_d)
    );

    // a redirect forces the register to drain even when decode stalls
    assign pc_load = redirect_valid | (out_valid & out_ready);

    fetch_pc_reg #(.START_ADDR(START_ADDR)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .load (pc_load),
        .d    (pc_d),
        .q    (pc_q)
    );

    assign imem_addr = pc_q;

    fetch_squash u_sq (
        .redirect_valid (redirect_valid),
        .pc             (pc_q),
        .inst           (imem_data),
        .valid          (out_valid),
        .pkt            (pkt)
    );

    assign out_pc   = pkt.pc;
    assign out_inst = pkt.inst;
endmodule

// File: rtl/fetch_pc_unit_chk.sv
module fetch_pc_unit_chk
    import fetch_pkg::*;
#(
    parameter addr_t START_ADDR = 32'h0000_1000
) (
    input logic            clk,
    input logic            rst,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] imem_addr,
    input logic [ILEN-1:0] imem_data,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_pc,
    input logic [ILEN-1:0] out_inst
);
    // R1
    reset_addr_chk: assert property (@(posedge clk)
        rst |=> imem_addr == START_ADDR);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !redirect_valid)
        |=> imem_addr == $past(imem_addr) + addr_t'(PC_STEP));

    // R3
    redirect_load_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> imem_addr == $past(redirect_pc));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_ready && !redirect_valid) |=> $stable(imem_addr) && $stable(out_pc));

    // R5
    squash_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !out_valid);

    // R6
    payload_pair_chk: assert property (@(posedge clk) disable iff (rst)
        out_pc == imem_addr && out_inst == imem_data);

    // R7
    redirect_over_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && !out_ready) |=> imem_addr == $past(redirect_pc));
endmodule

bind fetch_pc_unit fetch_pc_unit_chk #(.START_ADDR(START_ADDR)) u_chk (.*);

// File: tb/tb_fetch_pc_unit.sv
`timescale 1ns/1ps
module tb_fetch_pc_unit;
    localparam logic [31:0] START = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_pc = '0;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_pc;
    logic [31:0] out_inst;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc;
    string       addr_tag;

    always #2 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[17:2]};
    endfunction

    assign imem_data = mem_word(imem_addr);

    fetch_pc_unit #(.START_ADDR(START)) dut (
        .clk(clk), .rst(rst),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pc(out_pc), .out_inst(out_inst)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; redirect_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_pc = START;
        addr_tag = "R1";
    endtask

    // drive one cycle, compare outputs against the model, advance the model
    task automatic step(input logic rv, input logic [31:0] rpc, input logic rdy);
        @(negedge clk);
        redirect_valid = rv; redirect_pc = rpc; out_ready = rdy;
        #1;
        chk(addr_tag, "imem_addr", imem_addr, model_pc);
        chk("R6", "out_pc", out_pc, model_pc);
        chk("R6", "out_inst", out_inst, mem_word(model_pc));
        chk("R5", "out_valid", {31'b0, out_valid}, {31'b0, ~rv});
        if (rv) begin
            model_pc = rpc;
            addr_tag = rdy ? "R3" : "R7";
        end else if (rdy) begin
            model_pc = model_pc + 32'd4;
            addr_tag = "R2";
        end else begin
            addr_tag = "R4";
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        addr_tag = "R1";
        model_pc = START;
        do_reset();
        // R1 first address after reset, then R2 sequential stream
        for (int i = 0; i < 12; i++) step(1'b0, '0, 1'b1);
        // R4 stall pattern
        for (int i = 0; i < 8; i++) step(1'b0, '0, i[0]);
        // R3 redirect with decode ready, R5 squash
        step(1'b1, 32'h0000_0200, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
        // R7 redirect during stall
        step(1'b1, 32'h0000_8000, 1'b0);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);
        // back-to-back redirects
        step(1'b1, 32'h0000_0040, 1'b1);
        step(1'b1, 32'h0000_0080, 1'b0);
        step(1'b1, 32'h0000_00C0, 1'b1);
        step(1'b0, '0, 1'b1);
        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic rv;
            logic rdy;
            rv  = ($urandom % 8) == 0;
            rdy = ($urandom % 3) != 0;
            step(rv, {$urandom} & 32'h000F_FFFC, rdy);
        end
        // R1 reset in the middle of a run
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule